// File: doc/BRIEF.md
# Configuration Stream Sync Detector with Watchdog

This block sits on the receiving side of a byte-wide configuration port. On every rising edge of the configuration clock it takes in one byte, if the port is selected and set to write. It hunts for a fixed four-byte synchronisation pattern. Padding bytes of 0xFF ahead of the pattern have no effect. Once the pattern is found, the block counts the bytes of payload that follow and raises a completion flag when the programmed stream length has arrived.

While it is still hunting, a watchdog counts configuration clocks. If the programmed limit runs out before the pattern has been seen, the block enters a sticky failure state. It drives an active-high init-low indication and sets an error bit in the status word. The outcome is reported through a single-cycle sync pulse and through sticky flags collected in a status word. Firmware or a neighbouring sequencer reads these to decide whether to retry the load.

Top module: `cfg_sync_watch`

## Requirements
- R1: When four accepted bytes equal to 0x55, 0x99, 0xAA, 0x66 arrive in that order, `sync_pulse` is 1 in the cycle after the edge that accepts 0x66, and the lock flag (status bit 4) becomes 1 and stays 1.
- R2: 0xFF bytes sent before the pattern produce no sync pulse, are not counted as payload, and leave the hunt free to find the pattern that follows.
- R3: A partial match restarts correctly. A 0x55 that breaks a match counts as the first byte of a new match, so 0x55 0x55 0x99 0xAA 0x66 is detected. Any other mismatching byte clears the match, so 0x55 0x99 0x00 0xAA 0x66 is not detected.
- R4: A byte is accepted only on an edge where `port_sel` and `port_wr` are both 1. Cycles without acceptance neither advance nor break a partial match, and they never cause a sync pulse.
- R5: While hunting, the watchdog counts clocks from reset release. On the `wdog_limit`-th edge (`wdog_limit` ≥ 1; the smallest limit used in practice is 0x201 = 513), `init_low` and status bit 3 become 1.
- R6: Once the pattern is found, the watchdog stops. If the final pattern byte is accepted on the very edge on which the watchdog would expire, the sync wins and no timeout is flagged.
- R7: After a timeout, `init_low` stays 1 until reset, and later pattern bytes no longer produce a sync.
- R8: After lock, each accepted byte counts as payload. `stream_done` and status bit 0 become 1 on the edge that accepts the `stream_len`-th payload byte (`stream_len` ≥ 1). Both stay 1, and later bytes do not clear them.
- R9: An active-low `rst_n` clears the pulse, the flags, the counters and the whole status word to 0.
- R10: The status word has `stream_done` at bit 0, the timeout error at bit 3 and the lock flag at bit 4. All other bits read 0.
- R11: `sync_pulse` lasts exactly one cycle and fires at most once per reset, even if the pattern appears again in the payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration clock; bytes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | Port selected (active high) |
| port_wr | input | 1 | Transfer direction is write (1) |
| port_data | input | 8 | Incoming configuration byte |
| wdog_limit | input | WDOG_W | Watchdog limit in configuration clocks |
| stream_len | input | LEN_W | Expected payload length in bytes after the pattern |
| sync_pulse | output | 1 | One-cycle pulse when the pattern is detected |
| init_low | output | 1 | Sticky failure indication after a watchdog timeout |
| stream_done | output | 1 | Sticky flag: whole payload received |
| status_word | output | STATUS_W | Sticky status bits (done, timeout, lock) |

## Verification
The bench aims at the pattern boundaries. These cases are a repeated 0x55 that must restart the match, a foreign byte in the middle of the pattern, and idle or read cycles inside a pattern. A matcher that resets to zero on every mismatch would miss the repeated-0x55 case. One that treats idle cycles as mismatches would miss a pattern that has gaps in it. The watchdog is probed one edge before and on the expiry edge at the 513-clock minimum. It is also probed with the last pattern byte landing on the expiry edge, where a design that gives the timeout priority would wrongly flag an error. Random traffic with injected patterns and random limits and lengths is compared cycle by cycle against a bench model. This catches off-by-one payload counts, a done or error flag that is not sticky, and a sync pulse that fires again later in the payload.

// File: rtl/cfg_sync_pkg.sv
package cfg_sync_pkg;
   localparam int BYTE_W   = 8;
   localparam int SYNC_LEN = 4;

   // status word bit positions; a neighbouring sequencer decodes these
   localparam int ST_DONE_BIT = 0;
   localparam int ST_WTO_BIT  = 3;
   localparam int ST_LOCK_BIT = 4;

   typedef enum logic [1:0] {
      PH_HUNT   = 2'd0,
      PH_LOCKED = 2'd1,
      PH_FAILED = 2'd2
   } phase_e;

   function automatic logic [BYTE_W-1:0] sync_byte(input logic [1:0] pos);
      case (pos)
         2'd0:    return 8'h55;
         2'd1:    return 8'h99;
         2'd2:    return 8'hAA;
         default: return 8'h66;
      endcase
   endfunction
endpackage

// File: rtl/cfg_sync_matcher.sv
module cfg_sync_matcher
   import cfg_sync_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [BYTE_W-1:0] data,
   input  logic              expire,
   output phase_e            phase,
   output logic              sync_pulse
);
   logic [1:0] match_idx;
   logic       hit;
   logic       last_hit;
   logic       restart;

   assign hit      = (data == sync_byte(match_idx));
   assign last_hit = accept && hit && (match_idx == 2'(SYNC_LEN - 1));
   assign restart  = (data == sync_byte(2'd0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_HUNT;
         match_idx  <= 2'd0;
         sync_pulse <= 1'b0;
      end else begin
         sync_pulse <= 1'b0;
         if (phase == PH_HUNT) begin
            if (last_hit) begin
               phase      <= PH_LOCKED;
               sync_pulse <= 1'b1;
               match_idx  <= 2'd0;
            end else begin
               if (expire) phase <= PH_FAILED;
               if (accept) begin
                  if (hit)          match_idx <= match_idx + 2'd1;
                  else if (restart) match_idx <= 2'd1;
                  else              match_idx <= 2'd0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/cfg_wdog.sv
module cfg_wdog #(
   parameter int W  = 16,
   parameter bit EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         expire
);
   generate
      if (EN) begin : g_count
         logic [W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (run) cnt <= cnt + W'(1);
         end
         assign expire = run && ((cnt + W'(1)) == limit);
      end else begin : g_off
         logic unused_in;
         assign unused_in = ^{clk, rst_n, run, limit};
         assign expire    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cfg_stream_count.sv
module cfg_stream_count #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] len,
   output logic         done
);
   logic [W-1:0] cnt;
   logic [W-1:0] cnt_nxt;

   assign cnt_nxt = cnt + W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (en && !done) begin
         cnt <= cnt_nxt;
         if (cnt_nxt == len) done <= 1'b1;
      end
   end
endmodule

// File: rtl/cfg_sync_watch.sv
module cfg_sync_watch
   import cfg_sync_pkg::*;
#(
   parameter int WDOG_W   = 16,
   parameter int LEN_W    = 16,
   parameter int STATUS_W = 16,
   parameter bit WDOG_EN  = 1'b1
) (
   input  logic                cfg_clk,
   input  logic                rst_n,
   input  logic                port_sel,
   input  logic                port_wr,
   input  logic [BYTE_W-1:0]   port_data,
   input  logic [WDOG_W-1:0]   wdog_limit,
   input  logic [LEN_W-1:0]    stream_len,
   output logic                sync_pulse,
   output logic                init_low,
   output logic                stream_done,
   output logic [STATUS_W-1:0] status_word
);
   localparam int MIN_WDOG_W = 10;   // must hold the 513-clock minimum

   generate
      if (STATUS_W <= ST_LOCK_BIT) begin : g_bad_status
         $error("STATUS_W too narrow for the status bit map");
      end
      if (WDOG_W < MIN_WDOG_W) begin : g_bad_wdog
         $error("WDOG_W too narrow for the minimum watchdog limit");
      end
   endgenerate

   logic   accept;
   logic   expire;
   phase_e phase;

   assign accept = port_sel && port_wr;

   cfg_sync_matcher u_match (
      .clk        (cfg_clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .data       (port_data),
      .expire     (expire),
      .phase      (phase),
      .sync_pulse (sync_pulse)
   );

   cfg_wdog #(.W(WDOG_W), .EN(WDOG_EN)) u_wdog (
      .clk    (cfg_clk),
      .rst_n  (rst_n),
      .run    (phase == PH_HUNT),
      .limit  (wdog_limit),
      .expire (expire)
   );

   cfg_stream_count #(.W(LEN_W)) u_count (
      .clk   (cfg_clk),
      .rst_n (rst_n),
      .en    (accept && (phase == PH_LOCKED)),
      .len   (stream_len),
      .done  (stream_done)
   );

   assign init_low = (phase == PH_FAILED);

   always_comb begin
      status_word              = '0;
      status_word[ST_DONE_BIT] = stream_done;
      status_word[ST_WTO_BIT]  = init_low;
      status_word[ST_LOCK_BIT] = (phase == PH_LOCKED);
   end
endmodule

// File: rtl/cfg_sync_watch_chk.sv
module cfg_sync_watch_chk
   import cfg_sync_pkg::*;
#(
   parameter int STATUS_W = 16
) (
   input logic                cfg_clk,
   input logic                rst_n,
   input logic                port_sel,
   input logic                port_wr,
   input logic                sync_pulse,
   input logic                init_low,
   input logic                stream_done,
   input logic [STATUS_W-1:0] status_word
);
   // R11
   pulse_single_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      sync_pulse |=> !sync_pulse);
   // R1
   pulse_lock_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      sync_pulse |-> status_word[ST_LOCK_BIT]);
   // R7
   init_sticky_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      init_low |=> init_low);
   // R8
   done_sticky_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      stream_done |=> stream_done);
   // R8
   done_needs_lock_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      stream_done |-> status_word[ST_LOCK_BIT]);
   // R6
   lock_fail_excl_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      $onehot0({init_low, status_word[ST_LOCK_BIT]}));
   // R4
   idle_no_sync_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
      !(port_sel && port_wr) |=> !sync_pulse);
endmodule

bind cfg_sync_watch cfg_sync_watch_chk #(.STATUS_W(STATUS_W)) u_chk (
   .cfg_clk     (cfg_clk),
   .rst_n       (rst_n),
   .port_sel    (port_sel),
   .port_wr     (port_wr),
   .sync_pulse  (sync_pulse),
   .init_low    (init_low),
   .stream_done (stream_done),
   .status_word (status_word)
);

// File: tb/cfg_sync_watch_bench.sv
module cfg_sync_watch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  data = 8'h00;
   logic [15:0] lim_q = 16'd1000;
   logic [15:0] len_q = 16'd4;
   logic        sync_pulse, init_low, stream_done;
   logic [15:0] status_word;

   int checks = 0;
   int fails  = 0;

   // bench model state
   int m_st, m_idx, m_wc, m_bc;
   bit m_done, m_pulse;

   always #4 clk = ~clk;

   cfg_sync_watch u_cfg_sync_watch (
      .cfg_clk(clk), .rst_n(rst_n), .port_sel(sel), .port_wr(wr),
      .port_data(data), .wdog_limit(lim_q), .stream_len(len_q),
      .sync_pulse(sync_pulse), .init_low(init_low),
      .stream_done(stream_done), .status_word(status_word));

   function automatic logic [7:0] pat(input int i);
      case (i)
         0: return 8'h55;
         1: return 8'h99;
         2: return 8'hAA;
         default: return 8'h66;
      endcase
   endfunction

   function automatic logic [15:0] exp_status();
      logic [15:0] s = '0;
      s[0] = m_done;
      s[3] = (m_st == 2);
      s[4] = (m_st == 1);
      return s;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      chk("R1 sync_pulse", {31'd0, sync_pulse}, {31'd0, m_pulse});
      chk("R5 init_low", {31'd0, init_low}, {31'd0, (m_st == 2)});
      chk("R8 stream_done", {31'd0, stream_done}, {31'd0, m_done});
      chk("R10 status_word", {16'd0, status_word}, {16'd0, exp_status()});
   endtask

   // drive one cycle (called just after a falling edge), update model, sample at next falling edge
   task automatic cyc(input bit s, input bit w, input logic [7:0] d);
      bit acc, ex;
      sel = s; wr = w; data = d;
      acc = s && w;
      m_pulse = 0;
      if (m_st == 0) begin
         ex = ((m_wc + 1) % 65536 == int'(lim_q));
         m_wc++;
         if (acc && d == pat(m_idx) && m_idx == 3) begin
            m_st = 1; m_pulse = 1; m_idx = 0;
         end else begin
            if (ex) m_st = 2;
            if (acc) m_idx = (d == pat(m_idx)) ? m_idx + 1 : ((d == 8'h55) ? 1 : 0);
         end
      end else if (m_st == 1 && acc && !m_done) begin
         m_bc++;
         if (m_bc == int'(len_q)) m_done = 1;
      end
      @(negedge clk);
      compare_model();
   endtask

   task automatic wr_byte(input logic [7:0] d);
      cyc(1'b1, 1'b1, d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00);
   endtask

   task automatic send_sync();
      for (int i = 0; i < 4; i++) wr_byte(pat(i));
   endtask

   task automatic do_reset(input int lim, input int len);
      @(negedge clk);
      rst_n = 1'b0; sel = 0; wr = 0; data = 0;
      lim_q = 16'(lim); len_q = 16'(len);
      @(negedge clk);
      // R9: outputs cleared in reset
      chk("R9 reset sync_pulse", {31'd0, sync_pulse}, 32'd0);
      chk("R9 reset init_low", {31'd0, init_low}, 32'd0);
      chk("R9 reset stream_done", {31'd0, stream_done}, 32'd0);
      chk("R9 reset status_word", {16'd0, status_word}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      m_st = 0; m_idx = 0; m_wc = 0; m_bc = 0; m_done = 0; m_pulse = 0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: bench did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));

      // R2, R1, R11, R8: padding, sync, payload
      do_reset(1000, 5);
      for (int i = 0; i < 16; i++) wr_byte(8'hFF);
      chk("R2 no pulse on padding", {31'd0, sync_pulse}, 32'd0);
      chk("R2 padding leaves no lock", {27'd0, status_word[4:0]}, 32'd0);
      send_sync();
      chk("R1 pulse after last byte", {31'd0, sync_pulse}, 32'd1);
      chk("R1 lock bit", {31'd0, status_word[4]}, 32'd1);
      for (int i = 0; i < 4; i++) wr_byte(8'(i));
      chk("R11 pulse one cycle", {31'd0, sync_pulse}, 32'd0);
      chk("R8 not done early", {31'd0, stream_done}, 32'd0);
      wr_byte(8'h12);
      chk("R8 done on last byte", {31'd0, stream_done}, 32'd1);
      chk("R8 status bit0", {31'd0, status_word[0]}, 32'd1);
      send_sync();
      chk("R11 no second pulse", {31'd0, sync_pulse}, 32'd0);
      chk("R8 done sticky", {31'd0, stream_done}, 32'd1);

      // R3: restart on repeated 0x55
      do_reset(1000, 3);
      wr_byte(8'h55); send_sync();
      chk("R3 55 55 99 AA 66 detected", {31'd0, sync_pulse}, 32'd1);
      do_reset(1000, 3);
      wr_byte(8'h55); wr_byte(8'h99); wr_byte(8'h00); wr_byte(8'hAA); wr_byte(8'h66);
      chk("R3 broken pattern not detected", {31'd0, status_word[4]}, 32'd0);

      // R4: gaps and read cycles inside the pattern
      do_reset(1000, 3);
      wr_byte(8'h55);
      cyc(1'b0, 1'b1, 8'h00);
      cyc(1'b1, 1'b0, 8'h00);
      wr_byte(8'h99); wr_byte(8'hAA);
      cyc(1'b1, 1'b0, 8'h66);
      chk("R4 read cycle not accepted", {31'd0, status_word[4]}, 32'd0);
      wr_byte(8'h66);
      chk("R4 gaps do not break match", {31'd0, sync_pulse}, 32'd1);

      // R5, R10: minimum limit 513
      do_reset(513, 3);
      idle(512);
      chk("R5 no timeout one edge early", {31'd0, init_low}, 32'd0);
      idle(1);
      chk("R5 timeout on limit edge", {31'd0, init_low}, 32'd1);
      chk("R10 status only bit3", {16'd0, status_word}, 32'h0008);

      // R6: sync on the expiry edge wins
      do_reset(20, 3);
      idle(16);
      send_sync();
      chk("R6 sync wins at expiry", {31'd0, sync_pulse}, 32'd1);
      idle(30);
      chk("R6 watchdog stopped", {31'd0, init_low}, 32'd0);

      // R7: sync after timeout ignored
      do_reset(10, 3);
      idle(10);
      chk("R7 timed out", {31'd0, init_low}, 32'd1);
      send_sync();
      chk("R7 no sync after timeout", {31'd0, sync_pulse}, 32'd0);
      chk("R7 init_low sticky", {31'd0, init_low}, 32'd1);

      // random traffic against the model
      for (int r = 0; r < 20; r++) begin
         do_reset(30 + int'($urandom % 270), 1 + int'($urandom % 20));
         for (int k = 0; k < 400; k++) begin
            if ($urandom % 30 == 0) send_sync();
            else begin
               int p;
               logic [7:0] b;
               p = int'($urandom % 8);
               if (p < 4) b = pat(p);
               else if (p == 4) b = 8'hFF;
               else if (p == 5) b = 8'h55;
               else b = 8'($urandom);
               cyc(($urandom % 8) != 0, ($urandom % 8) != 0, b);
            end
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule